// File: doc/BRIEF.md
# Quadrature Mouse Position Port

This block tracks the position of a pointing device on two axes. Each axis has a pair of phase signals that are a quarter period apart. For each axis, the block samples both phases through a short register chain. It turns every legal single-phase transition into a step of plus or minus one, and it keeps the result in a wrapping position register.

Both positions and three raw active-low button lines are gathered into one bus word. Software reads that word through a plain select/read strobe pair. A select/write strobe clears both positions at once. Because the two axes sit in separate half-words, a narrow read can fetch either axis alone.

The decoder can be built in two ways, chosen at elaboration: a full lookup over the four sampled phase bits, or a reduced change-and-parity equation. Both forms give the same result.

Top module: `quad_mouse_port`

## Requirements
- R1: After reset, both positions are 0. With select and read high and all buttons released, the bus word is 32'h0000_7000.
- R2: Each phase input passes through two registers in series. A phase level driven just after clock edge P0 is captured at edge P1, and the position changes at edge P2.
- R3: Phase pairs are written as (A,B). The order 00, 01, 11, 10, 00 counts up by one for each transition.
- R4: The reverse order 00, 10, 11, 01, 00 counts down by one for each transition.
- R5: The position does not change when both sampled phases are unchanged. It also does not change when both phases flip between two samples.
- R6: The position is POS_W = 12 bits wide and wraps: 4095 plus one gives 0, and 0 minus one gives 4095.
- R7: While select and read are both high, the bus word holds the X position in bits 11:0 and the Y position in bits 27:16, and bits 31:28 and bit 15 are 0. At all other times the bus word is all zeros.
- R8: Bits 14, 13 and 12 of the read word carry the left, middle and right button lines as they are: 0 means pressed, 1 means released.
- R9: Select and write high at a clock edge clear both positions at that edge. A step that falls on the same edge is lost.
- R10: A transition on one axis never changes the other axis.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_pha | input | 1 | X axis phase A |
| x_phb | input | 1 | X axis phase B |
| y_pha | input | 1 | Y axis phase A |
| y_phb | input | 1 | Y axis phase B |
| btn_left_n | input | 1 | Left button, low when pressed |
| btn_mid_n | input | 1 | Middle button, low when pressed |
| btn_right_n | input | 1 | Right button, low when pressed |
| bus_sel | input | 1 | Port select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (clears both positions) |
| bus_rdata | output | 32 | Read data word |

## Verification
A write strobe and a decoded step can land on the same clock edge, and the clear must win. The bench provokes this by changing a Y phase one cycle before asserting the write. The step then reaches the counter exactly on the write edge. Y starts at 4094, so a lost clear would leave 4095 instead of 0. The bench checks that Y reads 0 at that edge and is still 0 two cycles later, after the stale sample has left the register chain.

// File: rtl/qm_pkg.sv
package qm_pkg;

   typedef enum logic [1:0] {
      MV_HOLD = 2'd0,
      MV_UP   = 2'd1,
      MV_DOWN = 2'd2
   } move_e;

   localparam int N_AXES   = 2;
   localparam int N_PHASES = 2;

endpackage

// File: rtl/qm_phase_sync.sv
module qm_phase_sync #(
   parameter int N_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_BITS-1:0] raw,
   output logic [N_BITS-1:0] cur,
   output logic [N_BITS-1:0] prev
);

   for (genvar i = 0; i < N_BITS; i++) begin : g_bit
      logic s_now;
      logic s_old;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_now <= 1'b0;
            s_old <= 1'b0;
         end else begin
            s_now <= raw[i];
            s_old <= s_now;
         end
      end

      assign cur[i]  = s_now;
      assign prev[i] = s_old;
   end

endmodule

// File: rtl/qm_step_decode.sv
module qm_step_decode
   import qm_pkg::*;
#(
   parameter int DECODE_STYLE = 0
) (
   input  logic  a_cur,
   input  logic  a_prev,
   input  logic  b_cur,
   input  logic  b_prev,
   output move_e move
);

   if (DECODE_STYLE == 0) begin : g_lookup
      always_comb begin
         unique case ({a_cur, a_prev, b_cur, b_prev})
            4'b1101, 4'b1011, 4'b0100, 4'b0010: move = MV_UP;
            4'b1110, 4'b0111, 4'b1000, 4'b0001: move = MV_DOWN;
            default:                            move = MV_HOLD;
         endcase
      end
   end else begin : g_equation
      logic a_moved;
      logic b_moved;
      logic same_lvl;

      assign a_moved  = a_cur ^ a_prev;
      assign b_moved  = b_cur ^ b_prev;
      assign same_lvl = ~(a_cur ^ b_cur);

      always_comb begin
         if (a_moved && !b_moved)
            move = same_lvl ? MV_UP : MV_DOWN;
         else if (b_moved && !a_moved)
            move = same_lvl ? MV_DOWN : MV_UP;
         else
            move = MV_HOLD;
      end
   end

endmodule

// File: rtl/qm_pos_counter.sv
module qm_pos_counter
   import qm_pkg::*;
#(
   parameter int POS_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  move_e            move,
   output logic [POS_W-1:0] pos
);

   localparam logic [POS_W-1:0] ONE = POS_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos <= '0;
      end else if (clr) begin
         pos <= '0;
      end else begin
         unique case (move)
            MV_UP:   pos <= pos + ONE;
            MV_DOWN: pos <= pos - ONE;
            default: pos <= pos;
         endcase
      end
   end

endmodule

// File: rtl/qm_axis.sv
module qm_axis
   import qm_pkg::*;
#(
   parameter int POS_W        = 12,
   parameter int DECODE_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pha,
   input  logic             phb,
   input  logic             clr,
   output logic [1:0]       ph_cur,
   output logic [1:0]       ph_prev,
   output logic [POS_W-1:0] pos
);

   move_e step;

   qm_phase_sync #(.N_BITS(N_PHASES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   ({phb, pha}),
      .cur   (ph_cur),
      .prev  (ph_prev)
   );

   qm_step_decode #(.DECODE_STYLE(DECODE_STYLE)) u_dec (
      .a_cur  (ph_cur[0]),
      .a_prev (ph_prev[0]),
      .b_cur  (ph_cur[1]),
      .b_prev (ph_prev[1]),
      .move   (step)
   );

   qm_pos_counter #(.POS_W(POS_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .move  (step),
      .pos   (pos)
   );

endmodule

// File: rtl/quad_mouse_port.sv
module quad_mouse_port
   import qm_pkg::*;
#(
   parameter int POS_W        = 12,
   parameter int BUS_W        = 32,
   parameter int X_LSB        = 0,
   parameter int BTN_LSB      = 12,
   parameter int Y_LSB        = 16,
   parameter int DECODE_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             x_pha,
   input  logic             x_phb,
   input  logic             y_pha,
   input  logic             y_phb,
   input  logic             btn_left_n,
   input  logic             btn_mid_n,
   input  logic             btn_right_n,
   input  logic             bus_sel,
   input  logic             bus_rd,
   input  logic             bus_wr,
   output logic [BUS_W-1:0] bus_rdata
);

   localparam int BTN_W = 3;

   if (POS_W < 2) begin : g_bad_width
      $error("quad_mouse_port: POS_W must be at least 2");
   end
   if (X_LSB + POS_W > BTN_LSB) begin : g_bad_x
      $error("quad_mouse_port: X field overlaps button field");
   end
   if (BTN_LSB + BTN_W > Y_LSB) begin : g_bad_btn
      $error("quad_mouse_port: button field overlaps Y field");
   end
   if (Y_LSB + POS_W > BUS_W) begin : g_bad_y
      $error("quad_mouse_port: Y field exceeds bus width");
   end
   if (DECODE_STYLE != 0 && DECODE_STYLE != 1) begin : g_bad_style
      $error("quad_mouse_port: DECODE_STYLE must be 0 or 1");
   end

   logic             clr_all;
   logic             rd_hit;
   logic [1:0]       ax_pha;
   logic [1:0]       ax_phb;
   logic [1:0]       cur_v  [N_AXES];
   logic [1:0]       prev_v [N_AXES];
   logic [POS_W-1:0] pos_v  [N_AXES];

   logic [POS_W-1:0] x_pos;
   logic [POS_W-1:0] y_pos;
   logic [1:0]       x_cur;
   logic [1:0]       x_prev;
   logic [1:0]       y_cur;
   logic [1:0]       y_prev;
   logic [BUS_W-1:0] word;

   assign clr_all = bus_sel & bus_wr;
   assign rd_hit  = bus_sel & bus_rd;
   assign ax_pha  = {y_pha, x_pha};
   assign ax_phb  = {y_phb, x_phb};

   for (genvar g = 0; g < N_AXES; g++) begin : g_axis
      qm_axis #(
         .POS_W        (POS_W),
         .DECODE_STYLE (DECODE_STYLE)
      ) u_axis (
         .clk     (clk),
         .rst_n   (rst_n),
         .pha     (ax_pha[g]),
         .phb     (ax_phb[g]),
         .clr     (clr_all),
         .ph_cur  (cur_v[g]),
         .ph_prev (prev_v[g]),
         .pos     (pos_v[g])
      );
   end

   assign x_pos  = pos_v[0];
   assign y_pos  = pos_v[1];
   assign x_cur  = cur_v[0];
   assign x_prev = prev_v[0];
   assign y_cur  = cur_v[1];
   assign y_prev = prev_v[1];

   always_comb begin
      word                       = '0;
      word[X_LSB +: POS_W]       = x_pos;
      word[Y_LSB +: POS_W]       = y_pos;
      word[BTN_LSB + 2]          = btn_left_n;
      word[BTN_LSB + 1]          = btn_mid_n;
      word[BTN_LSB]              = btn_right_n;
   end

   assign bus_rdata = rd_hit ? word : '0;

endmodule

// File: rtl/quad_mouse_port_chk.sv
module quad_mouse_port_chk #(
   parameter int POS_W   = 12,
   parameter int BUS_W   = 32,
   parameter int X_LSB   = 0,
   parameter int BTN_LSB = 12,
   parameter int Y_LSB   = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_rd,
   input logic             bus_wr,
   input logic             btn_left_n,
   input logic             btn_mid_n,
   input logic             btn_right_n,
   input logic [BUS_W-1:0] bus_rdata,
   input logic [POS_W-1:0] x_pos,
   input logic [POS_W-1:0] y_pos,
   input logic [1:0]       x_cur,
   input logic [1:0]       x_prev,
   input logic [1:0]       y_cur,
   input logic [1:0]       y_prev
);

   localparam logic [BUS_W-1:0] POS_MASK = BUS_W'((64'd1 << POS_W) - 64'd1);
   localparam logic [BUS_W-1:0] USED =
      (POS_MASK << X_LSB) | (POS_MASK << Y_LSB) | (BUS_W'(7) << BTN_LSB);
   localparam logic [POS_W-1:0] ONE = POS_W'(1);

   // R9
   clear_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr) |=> (x_pos == '0 && y_pos == '0));

   // R5
   x_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(bus_sel && bus_wr) && x_cur == x_prev) |=> $stable(x_pos));

   // R5
   y_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(bus_sel && bus_wr) && (y_cur ^ y_prev) == 2'b11) |=> $stable(y_pos));

   // R3 R4 R6
   x_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_wr) |=> (x_pos == $past(x_pos) ||
                                x_pos == $past(x_pos) + ONE ||
                                x_pos == $past(x_pos) - ONE));

   // R7
   idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_rd) |-> (bus_rdata == '0));

   // R7
   pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata & ~USED) == '0);

   // R8
   button_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_rd) |-> (bus_rdata[BTN_LSB + 2] == btn_left_n &&
                               bus_rdata[BTN_LSB + 1] == btn_mid_n &&
                               bus_rdata[BTN_LSB]     == btn_right_n));

endmodule

bind quad_mouse_port quad_mouse_port_chk #(
   .POS_W   (POS_W),
   .BUS_W   (BUS_W),
   .X_LSB   (X_LSB),
   .BTN_LSB (BTN_LSB),
   .Y_LSB   (Y_LSB)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_sel     (bus_sel),
   .bus_rd      (bus_rd),
   .bus_wr      (bus_wr),
   .btn_left_n  (btn_left_n),
   .btn_mid_n   (btn_mid_n),
   .btn_right_n (btn_right_n),
   .bus_rdata   (bus_rdata),
   .x_pos       (x_pos),
   .y_pos       (y_pos),
   .x_cur       (x_cur),
   .x_prev      (x_prev),
   .y_cur       (y_cur),
   .y_prev      (y_prev)
);

// File: tb/quad_mouse_port_test.sv
`timescale 1ns/1ps
module quad_mouse_port_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        x_pha = 1'b0, x_phb = 1'b0, y_pha = 1'b0, y_phb = 1'b0;
   logic        btn_l = 1'b1, btn_m = 1'b1, btn_r = 1'b1;
   logic        sel = 1'b1, rd = 1'b1, wr = 1'b0;
   logic [31:0] rdata;

   int tests = 0;
   int fails = 0;
   bit done = 0;
   int ph [2] = '{0, 0};

   // reference model state
   int m_pos [2];
   int m_hist_x [$];
   int m_hist_y [$];

   always #2.5 clk = ~clk;

   quad_mouse_port uut (
      .clk (clk), .rst_n (rst_n),
      .x_pha (x_pha), .x_phb (x_phb), .y_pha (y_pha), .y_phb (y_phb),
      .btn_left_n (btn_l), .btn_mid_n (btn_m), .btn_right_n (btn_r),
      .bus_sel (sel), .bus_rd (rd), .bus_wr (wr),
      .bus_rdata (rdata)
   );

   function automatic int gray_pos(input int ab);
      case (ab)
         0: return 0;
         1: return 1;
         3: return 2;
         default: return 3;
      endcase
   endfunction

   function automatic int delta(input int newer, input int older);
      int d;
      d = (gray_pos(newer) - gray_pos(older) + 4) % 4;
      if (d == 1) return 1;
      if (d == 3) return -1;
      return 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pos[0] = 0;
         m_pos[1] = 0;
         m_hist_x = '{0, 0};
         m_hist_y = '{0, 0};
      end else begin
         if (sel && wr) begin
            m_pos[0] = 0;
            m_pos[1] = 0;
         end else begin
            m_pos[0] = (m_pos[0] + delta(m_hist_x[1], m_hist_x[0]) + 4096) % 4096;
            m_pos[1] = (m_pos[1] + delta(m_hist_y[1], m_hist_y[0]) + 4096) % 4096;
         end
         m_hist_x.push_back({30'd0, x_pha, x_phb});
         m_hist_y.push_back({30'd0, y_pha, y_phb});
         void'(m_hist_x.pop_front());
         void'(m_hist_y.pop_front());
      end
   end

   function automatic logic [31:0] model_word();
      logic [31:0] w;
      w = '0;
      if (sel && rd) begin
         w[11:0]  = m_pos[0][11:0];
         w[27:16] = m_pos[1][11:0];
         w[14]    = btn_l;
         w[13]    = btn_m;
         w[12]    = btn_r;
      end
      return w;
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   // per-cycle comparison against the model (R7 layout, all functions)
   always @(negedge clk) begin
      if (rst_n && !done) check("R7 model", rdata, model_word());
   end

   task automatic tick(input int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic set_phase(input int axis);
      logic a, b;
      case (ph[axis])
         0: begin a = 0; b = 0; end
         1: begin a = 0; b = 1; end
         2: begin a = 1; b = 1; end
         default: begin a = 1; b = 0; end
      endcase
      if (axis == 0) begin x_pha = a; x_phb = b; end
      else begin y_pha = a; y_phb = b; end
   endtask

   // dir: +1 up, -1 down, 2 both phases flip
   task automatic move(input int axis, input int dir, input int n);
      for (int i = 0; i < n; i++) begin
         ph[axis] = (ph[axis] + dir + 4) % 4;
         set_phase(axis);
         tick(3);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", rdata, 32'h0000_7000);

      // R2 latency: drive after P0, no change after P1, change after P2
      tick(1);
      ph[0] = 1;
      set_phase(0);
      @(negedge clk);
      @(negedge clk);
      check("R2 after first edge", {20'd0, rdata[11:0]}, 32'd0);
      @(negedge clk);
      check("R2 after second edge", {20'd0, rdata[11:0]}, 32'd1);
      tick(1);

      // R3 up order on X
      move(0, 1, 9);
      @(negedge clk);
      check("R3", {20'd0, rdata[11:0]}, 32'd10);

      // R4 down order on Y, R10 X untouched
      tick(1);
      move(1, -1, 5);
      @(negedge clk);
      check("R4", {20'd0, rdata[27:16]}, 32'd4091);
      check("R10", {20'd0, rdata[11:0]}, 32'd10);

      // R5 double flip and idle hold
      tick(1);
      move(0, 2, 1);
      tick(6);
      @(negedge clk);
      check("R5", {20'd0, rdata[11:0]}, 32'd10);
      tick(1);
      move(0, 1, 1);
      @(negedge clk);
      check("R3 after double", {20'd0, rdata[11:0]}, 32'd11);

      // R9 clear both
      tick(1);
      sel = 1; wr = 1;
      tick(1);
      wr = 0;
      @(negedge clk);
      check("R9 clear", rdata & 32'h0FFF_0FFF, 32'd0);

      // R6 wrap both ways
      tick(1);
      move(0, -1, 1);
      @(negedge clk);
      check("R6 underflow", {20'd0, rdata[11:0]}, 32'd4095);
      tick(1);
      move(0, 1, 1);
      @(negedge clk);
      check("R6 overflow", {20'd0, rdata[11:0]}, 32'd0);

      // R9 clear colliding with a step on Y (Y at 4094)
      tick(1);
      move(1, -1, 2);
      @(negedge clk);
      check("R6 y", {20'd0, rdata[27:16]}, 32'd4094);
      tick(1);
      ph[1] = (ph[1] + 1) % 4;
      set_phase(1);
      tick(1);
      wr = 1;
      tick(1);
      wr = 0;
      @(negedge clk);
      check("R9 collision", {20'd0, rdata[27:16]}, 32'd0);
      tick(2);
      @(negedge clk);
      check("R9 collision later", {20'd0, rdata[27:16]}, 32'd0);

      // R7 no read strobe or no select gives zero
      tick(1);
      move(0, 1, 3);
      rd = 0;
      @(negedge clk);
      check("R7 no read", rdata, 32'd0);
      tick(1);
      rd = 1; sel = 0;
      @(negedge clk);
      check("R7 no select", rdata, 32'd0);
      tick(1);
      sel = 1;
      @(negedge clk);
      check("R7 layout", rdata, 32'h0000_7003);

      // R8 buttons
      tick(1);
      btn_l = 0;
      @(negedge clk);
      check("R8 left", rdata & 32'h0000_7000, 32'h0000_3000);
      tick(1);
      btn_l = 1; btn_m = 0; btn_r = 0;
      @(negedge clk);
      check("R8 mid right", rdata & 32'h0000_7000, 32'h0000_4000);
      tick(1);
      btn_m = 1; btn_r = 1;
      tick(2);
      @(negedge clk);
      finish_run();
   end

endmodule